// File: doc/BRIEF.md
# Folded Decimating FIR Filter

This block is the last filtering stage of a decimating receive chain. It takes a stream of 16-bit signed samples that an earlier, coarser decimator has already thinned out. It applies a programmable linear-phase FIR with symmetric coefficients and emits one 16-bit result for every `cfg_dec` samples it accepts. The filter can be up to 512 taps long, and the decimation factor can be anything from 1 to 16.

Every tap product is formed on one shared multiplier-accumulator. The sample history sits in a circular RAM. Only the first half of the coefficient set is stored in a second RAM, since the other half mirrors it. For each stored coefficient, the control section reads the two samples that share it, and the datapath adds them before the single multiply. A filter of N taps therefore needs ceil(N/2) multiply cycles per output. Software loads the half coefficient set through a simple write port. It sets length and decimation while the block is held in reset, then streams samples with a valid/ready handshake.

Top module: `fold_fir_decim`

## Requirements
- R1: For a length N (1 to 512), output m equals the rounded and saturated value of sum over i=0..N-1 of h[i]*x[n-1-i], where n is the number of samples accepted when the output was triggered and x[j] is the j-th accepted sample since reset. Coefficient word k (written with `coef_we` at `coef_addr`=k) supplies both h[k] and h[N-1-k].
- R2: With decimation factor D (1 to 16), exactly one output is produced for every D accepted samples, triggered by the D-th, 2D-th, ... accepted sample after reset.
- R3: History positions older than the first sample accepted since reset contribute zero, whatever the sample RAM held before reset.
- R4: For odd N the centre coefficient h[(N-1)/2] multiplies the centre sample exactly once.
- R5: `in_ready` is low while a multiply pass runs and the next accepted sample would complete a decimation group. A sample offered while `in_ready` is low is not taken and has no effect on any result.
- R6: The accumulated sum is rounded by adding 2^14 and shifting right arithmetically by 15 bits, then clamped to the range -32768..32767.
- R7: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R8: `out_valid` is a one-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_taps | input | 10 | Filter length N, 1 to 512; change only during reset |
| cfg_dec | input | 5 | Decimation factor D, 1 to 16; change only during reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 8 | Coefficient index k (0 to ceil(N/2)-1) |
| coef_data | input | 16 | Signed coefficient, 15 fractional bits |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Block can take the offered sample |
| out_valid | output | 1 | Output sample pulse |
| out_data | output | 16 | Signed rounded and saturated output |

## Verification
Several properties are checked on every clock. A pass never starts while another is being issued. The tap index stays inside the folded half. The two reads for the centre tap of an odd filter hit the same address. The write pointer steps once per accepted sample, the decimation count stays below D, and each output pulse follows the last product of a pass and is never repeated. The arithmetic itself can only be shown by the bench's scenarios. These cover exact convolution values for odd and even lengths and several factors, the zeroed history after a reset that follows earlier traffic, back-pressure when D is 1, and saturation in both directions.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // Flags that travel with each tap read through the pipeline
  typedef struct packed {
    logic first;   // first tap pair of a pass: restart accumulation
    logic last;    // final tap pair: emit the result
    logic zero_a;  // near sample precedes reset history
    logic zero_b;  // far sample precedes history or is the centre duplicate
  } tap_tag_t;
endpackage

// File: rtl/fir_ram.sv
module fir_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int MAX_TAPS = 512,
  parameter int MAX_DEC  = 16,
  localparam int SAW  = $clog2(2 * MAX_TAPS),
  localparam int KW   = $clog2(MAX_TAPS / 2),
  localparam int TW   = $clog2(MAX_TAPS + 1),
  localparam int DECW = $clog2(MAX_DEC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   cfg_taps,
  input  logic [DECW-1:0] cfg_dec,
  input  logic            in_valid,
  output logic            in_ready,
  output logic            wr_en,
  output logic [SAW-1:0]  wr_addr,
  output logic [SAW-1:0]  rd_a,
  output logic [SAW-1:0]  rd_b,
  output logic [KW-1:0]   coef_raddr,
  output logic            issue,
  output tap_tag_t        tag
);
  logic [SAW-1:0]  wp, base;
  logic [TW-1:0]   fill, fill_nxt, fill_s;
  logic [DECW-1:0] dec_cnt, last_dec;
  logic [KW-1:0]   k;
  logic            busy, accept, wrap, last_k, centre;
  logic [TW-1:0]   half, off_a, off_b;

  assign last_dec = DECW'(cfg_dec - 1'b1);
  assign in_ready = !(busy && (dec_cnt == last_dec));
  assign accept   = in_valid && in_ready;
  assign wrap     = accept && (dec_cnt == last_dec);
  assign fill_nxt = (fill < TW'(MAX_TAPS)) ? fill + 1'b1 : fill;

  assign half   = (cfg_taps + 1'b1) >> 1;
  assign last_k = (TW'(k) == half - 1'b1);
  assign centre = cfg_taps[0] && last_k;
  assign off_a  = TW'(k);
  assign off_b  = cfg_taps - 1'b1 - TW'(k);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      base    <= '0;
      fill    <= '0;
      fill_s  <= '0;
      dec_cnt <= '0;
      busy    <= 1'b0;
      k       <= '0;
    end else begin
      if (accept) begin
        wp      <= wp + 1'b1;
        fill    <= fill_nxt;
        dec_cnt <= wrap ? '0 : dec_cnt + 1'b1;
      end
      if (wrap) begin
        busy   <= 1'b1;
        k      <= '0;
        base   <= wp;
        fill_s <= fill_nxt;
      end else if (busy) begin
        if (last_k) busy <= 1'b0;
        else        k    <= k + 1'b1;
      end
    end
  end

  assign wr_en      = accept;
  assign wr_addr    = wp;
  assign rd_a       = base - SAW'(off_a);
  assign rd_b       = base - SAW'(off_b);
  assign coef_raddr = k;
  assign issue      = busy;
  assign tag.first  = (k == '0);
  assign tag.last   = last_k;
  assign tag.zero_a = (off_a >= fill_s);
  assign tag.zero_b = centre || (off_b >= fill_s);

  p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !busy);
  p_k_bound_r1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (TW'(k) < half));
  p_centre_same_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && centre) |-> (rd_a == rd_b));
  p_wp_step_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (wp == SAW'($past(wp) + 1'b1)));
  p_dec_bound_r2: assert property (@(posedge clk) disable iff (rst)
    dec_cnt < cfg_dec);
endmodule

// File: rtl/fir_mac.sv
module fir_mac
  import fir_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ACCW = 41,
  parameter int FRAC = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  tap_tag_t      tag,
  input  logic [DW-1:0] xa,
  input  logic [DW-1:0] xb,
  input  logic [CW-1:0] cf,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam logic signed [ACCW:0] HALF = (ACCW + 1)'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW:0] MAXV = (ACCW + 1)'(2 ** (DW - 1) - 1);
  localparam logic signed [ACCW:0] MINV = -((ACCW + 1)'(2 ** (DW - 1)));

  logic                     v1, v2, v3;
  tap_tag_t                 t1, t2, t3;
  logic signed [DW:0]       pa2, a1, b1;
  logic signed [CW-1:0]     cf2;
  logic signed [DW+CW:0]    prod3;
  logic signed [ACCW-1:0]   acc, total;
  logic signed [ACCW:0]     rnd, shf;
  logic [DW-1:0]            sat;

  // stage 1: RAM data present, fold the pair
  assign a1 = t1.zero_a ? '0 : (DW + 1)'($signed(xa));
  assign b1 = t1.zero_b ? '0 : (DW + 1)'($signed(xb));

  // stage 3: accumulate, round and clamp
  assign total = (t3.first ? '0 : acc) + ACCW'(prod3);
  assign rnd   = (ACCW + 1)'(total) + HALF;
  assign shf   = rnd >>> FRAC;
  assign sat   = (shf > MAXV) ? MAXV[DW-1:0] :
                 (shf < MINV) ? MINV[DW-1:0] : shf[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      t1 <= '0;   t2 <= '0;   t3 <= '0;
      pa2 <= '0;  cf2 <= '0;  prod3 <= '0;
      acc <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      v1 <= issue;
      t1 <= tag;
      v2 <= v1;
      t2 <= t1;
      pa2 <= a1 + b1;
      cf2 <= $signed(cf);
      v3 <= v2;
      t3 <= t2;
      prod3 <= pa2 * cf2;
      out_valid <= 1'b0;
      if (v3) begin
        acc <= total;
        if (t3.last) begin
          out_valid <= 1'b1;
          out_data  <= sat;
        end
      end
    end
  end

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_out_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(v3 && t3.last));
endmodule

// File: rtl/fold_fir_decim.sv
module fold_fir_decim
  import fir_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int MAX_TAPS = 512,
  parameter int MAX_DEC  = 16,
  parameter int FRAC     = 15,
  localparam int SDEPTH  = 2 * MAX_TAPS,
  localparam int SAW     = $clog2(SDEPTH),
  localparam int CDEPTH  = MAX_TAPS / 2,
  localparam int KW      = $clog2(CDEPTH),
  localparam int TW      = $clog2(MAX_TAPS + 1),
  localparam int DECW    = $clog2(MAX_DEC + 1),
  localparam int ACCW    = DW + CW + 1 + KW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   cfg_taps,
  input  logic [DECW-1:0] cfg_dec,
  input  logic            coef_we,
  input  logic [KW-1:0]   coef_addr,
  input  logic [CW-1:0]   coef_data,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [DW-1:0]   out_data
);
  logic           wr_en, issue;
  logic [SAW-1:0] wr_addr, rd_a, rd_b;
  logic [KW-1:0]  coef_raddr;
  logic [CW-1:0]  coef_q;
  tap_tag_t       tag;
  logic [SAW-1:0] rd_addr [2];
  logic [DW-1:0]  hist_q  [2];

  fir_ctrl #(.MAX_TAPS(MAX_TAPS), .MAX_DEC(MAX_DEC)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_taps(cfg_taps), .cfg_dec(cfg_dec),
    .in_valid(in_valid), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_a(rd_a), .rd_b(rd_b),
    .coef_raddr(coef_raddr), .issue(issue), .tag(tag)
  );

  assign rd_addr[0] = rd_a;
  assign rd_addr[1] = rd_b;

  // two identical history copies give one read port per pair member
  for (genvar g = 0; g < 2; g++) begin : g_hist
    fir_ram #(.W(DW), .DEPTH(SDEPTH)) u_hist (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
      .raddr(rd_addr[g]), .rdata(hist_q[g])
    );
  end

  fir_ram #(.W(CW), .DEPTH(CDEPTH)) u_coef (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
    .raddr(coef_raddr), .rdata(coef_q)
  );

  fir_mac #(.DW(DW), .CW(CW), .ACCW(ACCW), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst(rst), .issue(issue), .tag(tag),
    .xa(hist_q[0]), .xb(hist_q[1]), .cf(coef_q),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/sim_fold_fir_decim.sv
`timescale 1ns/1ps
module sim_fold_fir_decim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  cfg_taps = 10'd1;
  logic [4:0]  cfg_dec = 5'd1;
  logic        coef_we = 1'b0;
  logic [7:0]  coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int coefs [256];
  longint xs [4096];
  int nacc, n_out, cur_n, sat_hits;
  int exp_q [$];
  int win_q [$];
  string cur_tag = "R1";
  bit prev_ov = 0;

  always #10 clk = ~clk;

  fold_fir_decim u0 (
    .clk(clk), .rst(rst), .cfg_taps(cfg_taps), .cfg_dec(cfg_dec),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_out(int n, int taps);
    longint acc = 0;
    longint r;
    for (int i = 0; i < taps; i++) begin
      int idx = n - 1 - i;
      int ci = (i < (taps + 1) / 2) ? i : taps - 1 - i;
      if (idx >= 0) acc += longint'(coefs[ci]) * xs[idx];
    end
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (rst) prev_ov = 0;
    else begin
      if (out_valid && prev_ov)
        check(0, "R8", 1, 0);
      if (out_valid) begin
        int e, w;
        n_out++;
        if (exp_q.size() == 0) check(0, "R2", 1, 0);
        else begin
          e = exp_q.pop_front();
          w = win_q.pop_front();
          if (e == 32767 || e == -32768) sat_hits++;
          check(int'($signed(out_data)) == e, (w < cur_n) ? "R3" : cur_tag,
                $signed(out_data), e);
        end
      end
      prev_ov = out_valid;
    end
  end

  task automatic run_cfg(int taps, int dec, int count, int kind, string tg);
    int stalls = 0;
    int guard;
    cur_tag = tg; cur_n = taps;
    @(negedge clk);
    rst = 1; in_valid = 0;
    cfg_taps = 10'(taps); cfg_dec = 5'(dec);
    for (int k = 0; k < (taps + 1) / 2; k++) begin
      if (kind == 1) coefs[k] = 32767;
      else coefs[k] = int'($urandom_range(0, 8000)) - 4000;
      coef_we = 1; coef_addr = 8'(k); coef_data = 16'(coefs[k]);
      @(negedge clk);
    end
    coef_we = 0;
    // R7: reset state
    check(out_valid == 0 && in_ready == 1, "R7", {out_valid, in_ready}, 1);
    exp_q.delete(); win_q.delete();
    nacc = 0; n_out = 0; sat_hits = 0;
    rst = 0;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 1, "R7", {out_valid, in_ready}, 1);
    while (nacc < count) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 9) < 8);
      if (kind == 1) in_data = ((nacc / 20) % 2 == 0) ? 16'sd32767 : -16'sd32768;
      else in_data = 16'($urandom);
      #1;
      if (in_valid && in_ready) begin
        xs[nacc] = longint'($signed(in_data));
        nacc++;
        if (nacc % dec == 0) begin
          exp_q.push_back(ref_out(nacc, taps));
          win_q.push_back(nacc);
        end
      end else if (in_valid) stalls++;
    end
    @(negedge clk);
    in_valid = 0;
    guard = 0;
    while (exp_q.size() != 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (10) @(negedge clk);
    // R2: one output per group, none extra
    check(n_out == nacc / dec, "R2", n_out, nacc / dec);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    // R5: back-pressure seen when every sample completes a group
    if (dec == 1) check(stalls > 0, "R5", stalls, 1);
    // R6: saturation in both directions reached
    if (kind == 1) check(sat_hits >= 2, "R6", sat_hits, 2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    run_cfg(7, 3, 60, 0, "R4");
    run_cfg(8, 1, 40, 0, "R1");
    run_cfg(1, 1, 30, 0, "R4");
    run_cfg(32, 16, 160, 0, "R2");
    run_cfg(512, 4, 80, 0, "R1");
    run_cfg(15, 2, 60, 1, "R6");
    run_cfg(6, 5, 50, 0, "R3");
    run_cfg(9, 1, 40, 0, "R5");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule